// File: doc/BRIEF.md
# Workload-Driven Operating-Point Governor

This block chooses the supply and clock operating point of a processor from a fixed ladder of seven voltage/frequency pairs. Work items are queued in an internal first-in first-out buffer that the processor drains. A load filter sums the buffer occupancy over back-to-back measurement windows. It then asks for one step up when the buffer is mostly full, one step down when it is mostly empty, and no change otherwise. The aim is to run slowly enough to fill idle time, and to drop the voltage whenever less speed will do.

A sequencer carries out each step so that the clock never runs faster than the present voltage allows. On the way up it raises the voltage level first and the frequency level only after a settle interval. On the way down it lowers the frequency first and the voltage after the settle interval. While a step is in progress the sequencer flags itself busy and refuses new requests. The regulator and clock generator are not modelled; a settle counter stands in for them.

Top module: `opp_governor`

## Requirements
- R1: After reset both level outputs are 0, the outputs read 800 mV and 300 MHz, busy is low and the buffer reports empty.
- R2: The buffer returns words in the order written, and `pop_data_o` always shows the oldest word. `full_o` is set at FIFO_DEPTH words. A push while full and a pop while empty are ignored.
- R3: Measurement windows of WIN_CYC cycles run back to back from the first clock edge after reset release. Occupancy is added up on every edge of a window. A total of at least 3/4·FIFO_DEPTH·WIN_CYC (an average of 12 words at depth 16) requests one step up. A total of at most 1/4·FIFO_DEPTH·WIN_CYC (an average of 4) requests one step down. Anything between holds. There is at most one request per window.
- R4: Level n (0..6) maps to {800, 870, 950, 1050, 1150, 1250, 1300} mV and {300, 433, 533, 667, 800, 900, 1000} MHz for n in rising order.
- R5: On an up step, the voltage level rises by one on the edge after the window closes, and busy is set on that edge. The frequency level follows SETTLE_CYC edges later, and busy clears on that same edge.
- R6: On a down step, the frequency level falls by one on the edge after the window closes. The voltage level follows SETTLE_CYC edges later, and busy clears then.
- R7: The frequency level never exceeds the voltage level, and the two are equal whenever busy is low.
- R8: A request that arrives while busy is dropped and is not replayed later.
- R9: An up request at level 6 and a down request at level 0 leave the levels unchanged and do not set busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Write a work word |
| push_data_i | input | DATA_W | Work word to write |
| full_o | output | 1 | Buffer holds FIFO_DEPTH words |
| pop_i | input | 1 | Remove the oldest word |
| pop_data_o | output | DATA_W | Oldest word in the buffer |
| empty_o | output | 1 | Buffer holds no words |
| volt_lvl_o | output | 3 | Current voltage ladder index |
| freq_lvl_o | output | 3 | Current frequency ladder index |
| volt_mv_o | output | 11 | Supply target in millivolts |
| freq_mhz_o | output | 10 | Clock target in MHz |
| busy_o | output | 1 | Step in progress |

## Verification
A window closes on edge WIN_CYC, 2·WIN_CYC and so on after reset release. The first half of a step is due one edge later, and the second half SETTLE_CYC edges after that. The bench keeps its own window count from reset. It samples 5 cycles after each window close, which falls inside the settle interval and shows the half-done step, and again SETTLE_CYC+10 cycles after the close, which shows the finished step. Occupancy is changed only in the first cycles of a window. The thresholds have enough margin that a partly filled window still gives a known decision. For the exact-threshold levels, the pure second window is the one that decides.

// File: rtl/opp_pkg.sv
package opp_pkg;
   localparam int NUM_OPP = 7;
   localparam int LVL_W   = 3;
   localparam int MV_W    = 11;
   localparam int MHZ_W   = 10;

   typedef enum logic [1:0] {
      DEC_HOLD = 2'd0,
      DEC_UP   = 2'd1,
      DEC_DOWN = 2'd2
   } load_dec_e;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_RAISE = 2'd1,
      SEQ_LOWER = 2'd2
   } seq_state_e;

   function automatic logic [MV_W-1:0] opp_mv(input logic [LVL_W-1:0] lvl);
      case (lvl)
         3'd0:    return MV_W'(800);
         3'd1:    return MV_W'(870);
         3'd2:    return MV_W'(950);
         3'd3:    return MV_W'(1050);
         3'd4:    return MV_W'(1150);
         3'd5:    return MV_W'(1250);
         default: return MV_W'(1300);
      endcase
   endfunction

   function automatic logic [MHZ_W-1:0] opp_mhz(input logic [LVL_W-1:0] lvl);
      case (lvl)
         3'd0:    return MHZ_W'(300);
         3'd1:    return MHZ_W'(433);
         3'd2:    return MHZ_W'(533);
         3'd3:    return MHZ_W'(667);
         3'd4:    return MHZ_W'(800);
         3'd5:    return MHZ_W'(900);
         default: return MHZ_W'(1000);
      endcase
   endfunction
endpackage

// File: rtl/work_fifo.sv
module work_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [DATA_W-1:0] push_data_i,
   input  logic              pop_i,
   output logic [DATA_W-1:0] pop_data_o,
   output logic              full_o,
   output logic              empty_o,
   output logic [CNT_W-1:0]  count_o
);
   localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

   if (DEPTH < 2) begin : g_bad_depth
      $error("work_fifo: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("work_fifo: DATA_W must be positive");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0]  count;
   logic              do_push, do_pop;

   assign do_push = push_i && (count != CNT_W'(DEPTH));
   assign do_pop  = pop_i && (count != '0);

   if (POW2) begin : g_wrap_free
      assign wr_nxt = wr_ptr + PTR_W'(1);
      assign rd_nxt = rd_ptr + PTR_W'(1);
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end

   assign pop_data_o = mem[rd_ptr];
   assign full_o     = (count == CNT_W'(DEPTH));
   assign empty_o    = (count == '0);
   assign count_o    = count;

   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));
   assert_full_push_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && push_i && !pop_i) |=> $stable(count));
   assert_empty_pop_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (empty_o && pop_i && !push_i) |=> $stable(count) && $stable(rd_ptr));
endmodule

// File: rtl/load_filter.sv
module load_filter
   import opp_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int WIN   = 256,
   localparam int CNT_W  = $clog2(DEPTH + 1),
   localparam int WCNT_W = $clog2(WIN),
   localparam int SUM_W  = $clog2(WIN * DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] occ_i,
   output load_dec_e        dec_o
);
   localparam logic [SUM_W-1:0] HI_SUM = SUM_W'((3 * DEPTH * WIN + 3) / 4);
   localparam logic [SUM_W-1:0] LO_SUM = SUM_W'((DEPTH * WIN) / 4);

   if (WIN < 4) begin : g_bad_win
      $error("load_filter: WIN must be at least 4");
   end
   if (HI_SUM <= LO_SUM) begin : g_bad_thr
      $error("load_filter: thresholds overlap");
   end

   logic [WCNT_W-1:0] wcnt;
   logic [SUM_W-1:0]  acc, total;
   logic              closing;

   assign closing = (wcnt == WCNT_W'(WIN - 1));
   assign total   = acc + SUM_W'(occ_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcnt  <= '0;
         acc   <= '0;
         dec_o <= DEC_HOLD;
      end else begin
         dec_o <= DEC_HOLD;
         if (closing) begin
            wcnt <= '0;
            acc  <= '0;
            if (total >= HI_SUM)      dec_o <= DEC_UP;
            else if (total <= LO_SUM) dec_o <= DEC_DOWN;
         end else begin
            wcnt <= wcnt + WCNT_W'(1);
            acc  <= total;
         end
      end
   end

   assert_one_request_per_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_o != DEC_HOLD) |-> (wcnt == '0));
   assert_request_single_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_o != DEC_HOLD) |=> (dec_o == DEC_HOLD));
endmodule

// File: rtl/opp_sequencer.sv
module opp_sequencer
   import opp_pkg::*;
#(
   parameter int SETTLE = 24,
   localparam int SC_W  = (SETTLE > 1) ? $clog2(SETTLE) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  load_dec_e        dec_i,
   output logic [LVL_W-1:0] volt_lvl_o,
   output logic [LVL_W-1:0] freq_lvl_o,
   output logic             busy_o
);
   localparam logic [LVL_W-1:0] TOP  = LVL_W'(NUM_OPP - 1);
   localparam logic [SC_W-1:0]  LOAD = SC_W'(SETTLE - 1);

   if (SETTLE < 1) begin : g_bad_settle
      $error("opp_sequencer: SETTLE must be at least 1");
   end

   seq_state_e       state;
   logic [SC_W-1:0]  cnt;
   logic [LVL_W-1:0] volt, freq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
         cnt   <= '0;
         volt  <= '0;
         freq  <= '0;
      end else begin
         case (state)
            SEQ_IDLE: begin
               if (dec_i == DEC_UP && volt != TOP) begin
                  volt  <= volt + LVL_W'(1);
                  cnt   <= LOAD;
                  state <= SEQ_RAISE;
               end else if (dec_i == DEC_DOWN && freq != '0) begin
                  freq  <= freq - LVL_W'(1);
                  cnt   <= LOAD;
                  state <= SEQ_LOWER;
               end
            end
            SEQ_RAISE: begin
               if (cnt == '0) begin
                  freq  <= freq + LVL_W'(1);
                  state <= SEQ_IDLE;
               end else begin
                  cnt <= cnt - SC_W'(1);
               end
            end
            SEQ_LOWER: begin
               if (cnt == '0) begin
                  volt  <= volt - LVL_W'(1);
                  state <= SEQ_IDLE;
               end else begin
                  cnt <= cnt - SC_W'(1);
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   assign volt_lvl_o = volt;
   assign freq_lvl_o = freq;
   assign busy_o     = (state != SEQ_IDLE);

   assert_freq_under_volt_R7: assert property (@(posedge clk) disable iff (!rst_n)
      freq <= volt);
   assert_levels_match_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_IDLE) |-> (freq == volt));
   assert_raise_volt_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_IDLE && dec_i == DEC_UP && volt != TOP)
      |=> (volt == $past(volt) + LVL_W'(1)) && $stable(freq) && busy_o);
   assert_lower_freq_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_IDLE && dec_i == DEC_DOWN && freq != '0)
      |=> (freq == $past(freq) - LVL_W'(1)) && $stable(volt) && busy_o);
   assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && cnt != '0) |=> $stable(volt) && $stable(freq) && busy_o);
   assert_saturate_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_IDLE && dec_i == DEC_UP && volt == TOP) |=> !busy_o && $stable(volt));
   assert_saturate_bottom_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_IDLE && dec_i == DEC_DOWN && freq == '0) |=> !busy_o && $stable(freq));
endmodule

// File: rtl/opp_governor.sv
module opp_governor
   import opp_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int FIFO_DEPTH = 16,
   parameter int WIN_CYC    = 256,
   parameter int SETTLE_CYC = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [DATA_W-1:0] push_data_i,
   output logic              full_o,
   input  logic              pop_i,
   output logic [DATA_W-1:0] pop_data_o,
   output logic              empty_o,
   output logic [2:0]        volt_lvl_o,
   output logic [2:0]        freq_lvl_o,
   output logic [10:0]       volt_mv_o,
   output logic [9:0]        freq_mhz_o,
   output logic              busy_o
);
   localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

   logic [CNT_W-1:0] occ;
   load_dec_e        dec;

   work_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (push_i),
      .push_data_i (push_data_i),
      .pop_i       (pop_i),
      .pop_data_o  (pop_data_o),
      .full_o      (full_o),
      .empty_o     (empty_o),
      .count_o     (occ)
   );

   load_filter #(.DEPTH(FIFO_DEPTH), .WIN(WIN_CYC)) u_filter (
      .clk   (clk),
      .rst_n (rst_n),
      .occ_i (occ),
      .dec_o (dec)
   );

   opp_sequencer #(.SETTLE(SETTLE_CYC)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .dec_i      (dec),
      .volt_lvl_o (volt_lvl_o),
      .freq_lvl_o (freq_lvl_o),
      .busy_o     (busy_o)
   );

   assign volt_mv_o  = opp_mv(volt_lvl_o);
   assign freq_mhz_o = opp_mhz(freq_lvl_o);

   assert_mv_tracks_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(volt_lvl_o) |-> $changed(volt_mv_o));
endmodule

// File: tb/opp_governor_tb.sv
module opp_governor_tb;
   localparam int DW     = 8;
   localparam int DEPTH  = 16;
   localparam int WIN    = 256;
   localparam int SETTLE = 24;
   localparam int SLOW   = 300;

   // occupancy, windows, direction (+1/-1/0), first mixed window decides
   localparam int VEC [7][4] = '{
      '{16, 1,  1, 1},
      '{12, 2,  1, 0},
      '{11, 2,  0, 0},
      '{ 4, 2, -1, 0},
      '{ 5, 2,  0, 0},
      '{16, 5,  1, 1},
      '{ 0, 8, -1, 1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          push_i = 1'b0, pop_i = 1'b0;
   logic [DW-1:0] push_data_i = '0;
   logic          full_o, empty_o, busy_o;
   logic [DW-1:0] pop_data_o;
   logic [2:0]    volt_lvl_o, freq_lvl_o;
   logic [10:0]   volt_mv_o;
   logic [9:0]    freq_mhz_o;
   logic          s_full, s_empty, s_busy;
   logic [DW-1:0] s_data;
   logic [2:0]    s_volt, s_freq;
   logic [10:0]   s_mv;
   logic [9:0]    s_mhz;

   int n_chk = 0, n_fail = 0;
   int tick = 0;
   int occ = 0;
   logic [DW-1:0] wr_seq = '0, rd_seq = '0;

   always #10 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) tick <= 0;
      else        tick <= (tick == WIN - 1) ? 0 : tick + 1;
   end

   opp_governor #(.DATA_W(DW), .FIFO_DEPTH(DEPTH), .WIN_CYC(WIN), .SETTLE_CYC(SETTLE)) u_dut (
      .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i), .full_o(full_o),
      .pop_i(pop_i), .pop_data_o(pop_data_o), .empty_o(empty_o), .volt_lvl_o(volt_lvl_o),
      .freq_lvl_o(freq_lvl_o), .volt_mv_o(volt_mv_o), .freq_mhz_o(freq_mhz_o), .busy_o(busy_o)
   );

   opp_governor #(.DATA_W(DW), .FIFO_DEPTH(DEPTH), .WIN_CYC(WIN), .SETTLE_CYC(SLOW)) u_slow (
      .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i), .full_o(s_full),
      .pop_i(pop_i), .pop_data_o(s_data), .empty_o(s_empty), .volt_lvl_o(s_volt),
      .freq_lvl_o(s_freq), .volt_mv_o(s_mv), .freq_mhz_o(s_mhz), .busy_o(s_busy)
   );

   function automatic int exp_mv(input int l);
      case (l)
         0: return 800;  1: return 870;  2: return 950;  3: return 1050;
         4: return 1150; 5: return 1250; default: return 1300;
      endcase
   endfunction

   function automatic int exp_mhz(input int l);
      case (l)
         0: return 300; 1: return 433; 2: return 533; 3: return 667;
         4: return 800; 5: return 900; default: return 1000;
      endcase
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wait_boundary();
      do cyc(1); while (tick != 0);
   endtask

   task automatic push_one(input logic [DW-1:0] d);
      push_i = 1'b1;
      push_data_i = d;
      cyc(1);
      push_i = 1'b0;
   endtask

   task automatic pop_one();
      chk("R2 fifo order", int'(pop_data_o), int'(rd_seq));
      rd_seq = rd_seq + 1'b1;
      pop_i = 1'b1;
      cyc(1);
      pop_i = 1'b0;
   endtask

   task automatic set_occ(input int target);
      while (occ < target) begin
         push_one(wr_seq);
         wr_seq = wr_seq + 1'b1;
         occ++;
      end
      while (occ > target) begin
         pop_one();
         occ--;
      end
   endtask

   task automatic chk_level(input string tag, input int lvl);
      chk({tag, " volt"}, int'(volt_lvl_o), lvl);
      chk({tag, " freq"}, int'(freq_lvl_o), lvl);
      chk({tag, " busy"}, int'(busy_o), 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      int lvl;
      cyc(4);
      // R1 reset state
      chk("R1 volt lvl", int'(volt_lvl_o), 0);
      chk("R1 freq lvl", int'(freq_lvl_o), 0);
      chk("R1 mV", int'(volt_mv_o), 800);
      chk("R1 MHz", int'(freq_mhz_o), 300);
      chk("R1 busy", int'(busy_o), 0);
      chk("R1 empty", int'(empty_o), 1);
      rst_n = 1'b1;
      cyc(1);

      // R8: a second request while a slow step settles is dropped
      wait_boundary();
      set_occ(16);
      wait_boundary();
      cyc(5);
      chk("R5 raise volt first", int'(volt_lvl_o), 1);
      chk("R5 raise freq waits", int'(freq_lvl_o), 0);
      chk("R5 busy in raise", int'(busy_o), 1);
      wait_boundary();
      cyc(5);
      chk("R5 second raise volt", int'(volt_lvl_o), 2);
      chk("R8 slow still busy", int'(s_busy), 1);
      chk("R8 slow volt", int'(s_volt), 1);
      chk("R7 slow freq below volt", int'(s_freq), 0);
      cyc(55);
      chk("R8 slow volt after settle", int'(s_volt), 1);
      chk("R8 slow freq after settle", int'(s_freq), 1);
      chk("R8 slow idle", int'(s_busy), 0);
      chk_level("R5 fast after two steps", 2);
      set_occ(8);
      lvl = 2;

      // table of occupancy patterns
      for (int v = 0; v < 7; v++) begin
         wait_boundary();
         set_occ(VEC[v][0]);
         for (int i = 0; i < VEC[v][1]; i++) begin
            bit decides;
            wait_boundary();
            cyc(5);
            decides = (i > 0) || (VEC[v][3] == 1);
            if (decides && VEC[v][2] > 0 && lvl < 6) begin
               chk("R5 up volt leads", int'(volt_lvl_o), lvl + 1);
               chk("R5 up freq lags", int'(freq_lvl_o), lvl);
               chk("R5 up busy", int'(busy_o), 1);
               lvl++;
            end else if (decides && VEC[v][2] < 0 && lvl > 0) begin
               chk("R6 down freq leads", int'(freq_lvl_o), lvl - 1);
               chk("R6 down volt lags", int'(volt_lvl_o), lvl);
               chk("R6 down busy", int'(busy_o), 1);
               lvl--;
            end else begin
               chk_level("R3 R9 hold or saturate", lvl);
            end
         end
         cyc(SETTLE + 10);
         chk_level("R7 settled", lvl);
         chk("R4 mV", int'(volt_mv_o), exp_mv(lvl));
         chk("R4 MHz", int'(freq_mhz_o), exp_mhz(lvl));
         set_occ(8);
      end
      chk("R9 bottom reached", lvl, 0);

      // R2 buffer corners
      set_occ(16);
      chk("R2 full flag", int'(full_o), 1);
      push_one(8'hEE);
      chk("R2 still full", int'(full_o), 1);
      set_occ(0);
      chk("R2 empty flag", int'(empty_o), 1);
      pop_i = 1'b1;
      cyc(1);
      pop_i = 1'b0;
      chk("R2 pop on empty", int'(empty_o), 1);
      set_occ(1);
      chk("R2 not empty", int'(empty_o), 0);
      set_occ(0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule